// File: doc/BRIEF.md
# Coprocessor control and error unit

This block is the host-facing control front end of a small vector rendering engine. A 32-bit register bus reaches a window of configuration registers: run/stop and enables, latched error causes, a pair of memory bound limits, a plane mask, an 8-bit raster operation, a queue overflow counter, a diagnostics word, an identity word, an initial value for register zero and a soft-reset trigger. The unit owns the run bit that starts and stops the engine, collects error events from the datapath into sticky flags and raises an interrupt when enabled.

Two further address windows reach the engine's 128-entry register file. One writes a register straight through a one-cycle write strobe, and it is honoured only while the engine is stopped. The other turns a register write into an entry of the instruction queue, which the datapath drains through a valid/pop interface. The instruction port pushes raw instruction words into the same queue. The whole map appears a second time 0x1000 higher. In that copy the two bound registers cannot be written, so they can be exposed to less trusted software.

Top module: `vcop_ctrl`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0000_8000, with only bit 15 (queue empty) set. The run, irq, q_valid and rf_we outputs are all low.
- R2: The plane mask (0x10), lower bound (0x08), upper bound (0x0C), diagnostics (0x1C) and register-zero initial value (0x2C) are 32-bit read/write registers. The raster-op register (0x14) keeps only bits 7:0, and its upper bits read zero. The identity word (0x28) reads the architecture code in bits 7:0 and the chip revision in bits 15:8, with the rest zero.
- R3: Address bit 12 selects a mirror of the whole map. In the mirror every register reads the same as at its base offset and every register other than the two bounds is written the same way. Writes to the bounds at 0x1008 and 0x100C are ignored.
- R4: A write at 0x100 + 4·n while the run bit is clear produces rf_we high for exactly the cycle after the write, with rf_idx = n and rf_wdata equal to the written data.
- R5: A write at 0x100 + 4·n while the run bit is set produces no rf_we pulse. It sets error flag bit 3.
- R6: Control-word bits 5:0 are sticky error flags. Each is set by the matching err_evt bit in any cycle. Writing a 1 to the bit at offset 0x00 or 0x04 clears it, and a set in the same cycle as a clear wins. The error register (0x04) shows the flags in bits 5:0.
- R7: irq rises one cycle after any error flag is set while control bit 7 (interrupt enable) is 1. It falls one cycle after the flags clear or the enable drops. Error-register bit 7 reads (any flag AND enable).
- R8: A write at 0x300 + 4·n pushes an entry with q_kind=1, q_idx=n and the written data. A write at 0x20 pushes q_kind=0, q_idx=0 and the data. Entries leave in push order: q_valid is high while the queue holds an entry, q_pop removes the head, and control bit 15 reads 1 exactly when the queue is empty.
- R9: A push into a full queue is dropped. It increments the overflow counter (0x18, saturating) and sets error flag bit 5. Any write to 0x18 clears the counter.
- R10: Any write to 0x30 empties the queue and clears the error flags, the bit-13 write indication and the run bit. The enables, bounds, mask and other configuration are kept.
- R11: Control bit 14 is the run bit and drives run. Bit 12 drives pb_en. Bit 13 is set by eng_wrote, held, and cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| err_evt | input | 6 | Error events from the datapath |
| eng_wrote | input | 1 | Engine performed a memory write |
| run | output | 1 | Engine run bit |
| pb_en | output | 1 | Bound checking enable |
| irq | output | 1 | Error interrupt, registered |
| lo_bound | output | 32 | Lower bound register |
| hi_bound | output | 32 | Upper bound register |
| plane_mask | output | 32 | Plane mask register |
| rop | output | 8 | Raster operation code |
| r0_init | output | 32 | Initial value for register zero |
| rf_we | output | 1 | Direct register-file write strobe |
| rf_idx | output | 7 | Direct write register index |
| rf_wdata | output | 32 | Direct write data |
| q_valid | output | 1 | Queue head entry valid |
| q_kind | output | 1 | Head entry kind: 1 register write, 0 instruction |
| q_idx | output | 7 | Head entry register index |
| q_data | output | 32 | Head entry data |
| q_pop | input | 1 | Remove queue head |

## Verification
The bench builds the unit with a four-entry queue so that a fifth push reaches the full-queue drop, the overflow count and the bit-5 flag within a few bus cycles. It also sets a non-default architecture code (0x5C) and revision (0x2A), so the identity word check can tell the parameter fields apart. The register file keeps its default 128 entries, which lets the bench reach both the first and the last direct-write index.

// File: rtl/vcop_pkg.sv
package vcop_pkg;

  localparam int ADDR_W     = 13;
  localparam int BUS_W      = 32;
  localparam int MIRROR_BIT = 12;

  localparam logic [11:0] OFS_CTL    = 12'h000;
  localparam logic [11:0] OFS_ERR    = 12'h004;
  localparam logic [11:0] OFS_LO     = 12'h008;
  localparam logic [11:0] OFS_HI     = 12'h00C;
  localparam logic [11:0] OFS_PMASK  = 12'h010;
  localparam logic [11:0] OFS_ROP    = 12'h014;
  localparam logic [11:0] OFS_OVF    = 12'h018;
  localparam logic [11:0] OFS_DIAG   = 12'h01C;
  localparam logic [11:0] OFS_INSN   = 12'h020;
  localparam logic [11:0] OFS_ID     = 12'h028;
  localparam logic [11:0] OFS_R0I    = 12'h02C;
  localparam logic [11:0] OFS_SRST   = 12'h030;
  localparam logic [11:0] OFS_DIRECT = 12'h100;
  localparam logic [11:0] OFS_QUEUED = 12'h300;

  localparam int NUM_ERR     = 6;
  localparam int ERR_BAD_REG = 3;
  localparam int ERR_Q_OVF   = 5;

  localparam int B_IE = 7;
  localparam int B_PB = 12;
  localparam int B_WO = 13;
  localparam int B_GO = 14;
  localparam int B_MT = 15;

  typedef enum logic [3:0] {
    T_NONE, T_CTL, T_ERR, T_LO, T_HI, T_PMASK, T_ROP, T_OVF,
    T_DIAG, T_INSN, T_ID, T_R0I, T_SRST, T_DIRECT, T_QUEUED
  } tgt_e;

endpackage

// File: rtl/vcop_decode.sv
module vcop_decode
  import vcop_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              mirror
);

  localparam logic [11:0] WIN = 12'(4 * NUM_REGS);

  logic [11:0] off;
  logic [11:0] rel_d;
  logic [11:0] rel_q;
  logic        in_d;
  logic        in_q;

  always_comb begin
    off    = addr[11:0];
    mirror = addr[MIRROR_BIT];
    rel_d  = off - OFS_DIRECT;
    rel_q  = off - OFS_QUEUED;
    in_d   = (off >= OFS_DIRECT) && (rel_d < WIN);
    in_q   = (off >= OFS_QUEUED) && (rel_q < WIN);
    idx    = in_d ? rel_d[IDX_W+1:2] : rel_q[IDX_W+1:2];
    if (in_d) begin
      tgt = T_DIRECT;
    end else if (in_q) begin
      tgt = T_QUEUED;
    end else begin
      case (off)
        OFS_CTL:   tgt = T_CTL;
        OFS_ERR:   tgt = T_ERR;
        OFS_LO:    tgt = T_LO;
        OFS_HI:    tgt = T_HI;
        OFS_PMASK: tgt = T_PMASK;
        OFS_ROP:   tgt = T_ROP;
        OFS_OVF:   tgt = T_OVF;
        OFS_DIAG:  tgt = T_DIAG;
        OFS_INSN:  tgt = T_INSN;
        OFS_ID:    tgt = T_ID;
        OFS_R0I:   tgt = T_R0I;
        OFS_SRST:  tgt = T_SRST;
        default:   tgt = T_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vcop_err.sv
module vcop_err #(
  parameter int NUM_ERR = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] set_vec,
  input  logic [NUM_ERR-1:0] clr_vec,
  input  logic               srst,
  input  logic               ie,
  output logic [NUM_ERR-1:0] flags,
  output logic               irq
);

  // set has priority over a clear in the same cycle; soft reset beats both
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= (|flags) & ie;
    end
  end

endmodule

// File: rtl/vcop_fifo.sv
module vcop_fifo #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp;
  logic [AW:0]      rp;
  logic             do_push;
  logic             do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  // storage carries no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= wdata;
  end

endmodule

// File: rtl/vcop_ctrl.sv
module vcop_ctrl
  import vcop_pkg::*;
#(
  parameter int         NUM_REGS    = 128,
  parameter int         QUEUE_DEPTH = 16,
  parameter int         OVF_W       = 16,
  parameter logic [7:0] ARCH_CODE   = 8'h21,
  parameter logic [7:0] CHIP_REV    = 8'h03,
  localparam int        IDX_W       = $clog2(NUM_REGS),
  localparam int        ENT_W       = 1 + IDX_W + BUS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               eng_wrote,
  output logic               run,
  output logic               pb_en,
  output logic               irq,
  output logic [BUS_W-1:0]   lo_bound,
  output logic [BUS_W-1:0]   hi_bound,
  output logic [BUS_W-1:0]   plane_mask,
  output logic [7:0]         rop,
  output logic [BUS_W-1:0]   r0_init,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_idx,
  output logic [BUS_W-1:0]   rf_wdata,
  output logic               q_valid,
  output logic               q_kind,
  output logic [IDX_W-1:0]   q_idx,
  output logic [BUS_W-1:0]   q_data,
  input  logic               q_pop
);

  tgt_e             tgt;
  logic [IDX_W-1:0] idx;
  logic             mirror;
  logic             wr;
  logic             rd;

  logic             go_q, ie_q, pb_q, wo_q;
  logic [BUS_W-1:0] lo_q, hi_q, pmask_q, diag_q, r0i_q;
  logic [7:0]       rop_q;
  logic [OVF_W-1:0] ovf_q;

  logic [NUM_ERR-1:0] flags;
  logic [NUM_ERR-1:0] set_vec;
  logic [NUM_ERR-1:0] clr_vec;
  logic               irq_now;

  logic             srst_req;
  logic             dir_ok;
  logic             dir_bad;
  logic             push_req;
  logic             q_full;
  logic             q_empty;
  logic             overflow;
  logic [ENT_W-1:0] push_ent;
  logic [ENT_W-1:0] head_ent;

  logic [BUS_W-1:0] ctl_word;
  logic [BUS_W-1:0] err_word;
  logic [BUS_W-1:0] rd_mux;

  vcop_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .addr   (bus_addr),
    .tgt    (tgt),
    .idx    (idx),
    .mirror (mirror)
  );

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign srst_req = wr && (tgt == T_SRST);
  assign dir_ok   = wr && (tgt == T_DIRECT) && !go_q;
  assign dir_bad  = wr && (tgt == T_DIRECT) && go_q;
  assign push_req = wr && ((tgt == T_QUEUED) || (tgt == T_INSN));
  assign overflow = push_req && q_full;
  assign push_ent = (tgt == T_QUEUED) ? {1'b1, idx, bus_wdata}
                                      : {1'b0, {IDX_W{1'b0}}, bus_wdata};

  // ---------------- error flags and interrupt ----------------
  always_comb begin
    set_vec              = err_evt;
    set_vec[ERR_BAD_REG] = err_evt[ERR_BAD_REG] | dir_bad;
    set_vec[ERR_Q_OVF]   = err_evt[ERR_Q_OVF] | overflow;
    clr_vec = (wr && ((tgt == T_CTL) || (tgt == T_ERR))) ?
              bus_wdata[NUM_ERR-1:0] : '0;
  end

  vcop_err #(.NUM_ERR(NUM_ERR)) u_err (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .srst    (srst_req),
    .ie      (ie_q),
    .flags   (flags),
    .irq     (irq)
  );

  assign irq_now = (|flags) & ie_q;

  // ---------------- instruction queue ----------------
  vcop_fifo #(.WIDTH(ENT_W), .DEPTH(QUEUE_DEPTH)) u_q (
    .clk   (clk),
    .rst   (rst),
    .clr   (srst_req),
    .push  (push_req),
    .wdata (push_ent),
    .pop   (q_pop),
    .rdata (head_ent),
    .empty (q_empty),
    .full  (q_full)
  );

  assign q_valid = !q_empty;
  assign q_kind  = head_ent[ENT_W-1];
  assign q_idx   = head_ent[BUS_W +: IDX_W];
  assign q_data  = head_ent[BUS_W-1:0];

  // ---------------- control bits ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      go_q <= 1'b0;
      ie_q <= 1'b0;
      pb_q <= 1'b0;
      wo_q <= 1'b0;
    end else if (srst_req) begin
      go_q <= 1'b0;
      wo_q <= 1'b0;
    end else begin
      if (wr && (tgt == T_CTL)) begin
        go_q <= bus_wdata[B_GO];
        ie_q <= bus_wdata[B_IE];
        pb_q <= bus_wdata[B_PB];
      end
      wo_q <= (wo_q & ~(wr && (tgt == T_CTL) && bus_wdata[B_WO])) | eng_wrote;
    end
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      pmask_q <= '0;
      rop_q   <= '0;
      diag_q  <= '0;
      r0i_q   <= '0;
    end else if (wr) begin
      case (tgt)
        T_LO:    if (!mirror) lo_q <= bus_wdata;
        T_HI:    if (!mirror) hi_q <= bus_wdata;
        T_PMASK: pmask_q <= bus_wdata;
        T_ROP:   rop_q   <= bus_wdata[7:0];
        T_DIAG:  diag_q  <= bus_wdata;
        T_R0I:   r0i_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // saturating overflow count, cleared by any write to its offset
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
    end else if (wr && (tgt == T_OVF)) begin
      ovf_q <= '0;
    end else if (overflow && (ovf_q != '1)) begin
      ovf_q <= ovf_q + 1'b1;
    end
  end

  // ---------------- direct register-file write ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_idx   <= '0;
      rf_wdata <= '0;
    end else begin
      rf_we <= dir_ok;
      if (dir_ok) begin
        rf_idx   <= idx;
        rf_wdata <= bus_wdata;
      end
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    ctl_word                = '0;
    ctl_word[NUM_ERR-1:0]   = flags;
    ctl_word[B_IE]          = ie_q;
    ctl_word[B_PB]          = pb_q;
    ctl_word[B_WO]          = wo_q;
    ctl_word[B_GO]          = go_q;
    ctl_word[B_MT]          = q_empty;
    err_word                = '0;
    err_word[NUM_ERR-1:0]   = flags;
    err_word[B_IE]          = irq_now;
    case (tgt)
      T_CTL:   rd_mux = ctl_word;
      T_ERR:   rd_mux = err_word;
      T_LO:    rd_mux = lo_q;
      T_HI:    rd_mux = hi_q;
      T_PMASK: rd_mux = pmask_q;
      T_ROP:   rd_mux = {24'b0, rop_q};
      T_OVF:   rd_mux = BUS_W'(ovf_q);
      T_DIAG:  rd_mux = diag_q;
      T_ID:    rd_mux = {16'b0, CHIP_REV, ARCH_CODE};
      T_R0I:   rd_mux = r0i_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign run        = go_q;
  assign pb_en      = pb_q;
  assign lo_bound   = lo_q;
  assign hi_bound   = hi_q;
  assign plane_mask = pmask_q;
  assign rop        = rop_q;
  assign r0_init    = r0i_q;

endmodule

// File: rtl/vcop_ctrl_chk.sv
module vcop_ctrl_chk #(
  parameter int NUM_ERR = 6,
  parameter int OVF_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               rf_we,
  input logic               irq,
  input logic               ie,
  input logic [NUM_ERR-1:0] flags,
  input logic [NUM_ERR-1:0] clr_vec,
  input logic               srst,
  input logic               push,
  input logic               full,
  input logic [OVF_W-1:0]   ovf_cnt,
  input logic               q_valid
);

  // R4 / R5: strobe only follows a cycle with the engine stopped
  a_r4_direct_only_stopped: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !$past(run));

  // R6: a flag falls only through a clear or a soft reset
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(srst) |-> (($past(flags) & ~$past(clr_vec) & ~flags) == '0));

  // R7: interrupt needs the enable and a flag in the previous cycle
  a_r7_irq_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ie) && ($past(flags) != '0)));

  // R9: full-queue push counts and flags
  a_r9_ovf_count: assert property (@(posedge clk) disable iff (rst)
    (push && full && (ovf_cnt != '1)) |=> (ovf_cnt == $past(ovf_cnt) + 1'b1));

  a_r9_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> flags[NUM_ERR-1]);

  // R10: soft reset empties queue, clears flags and run
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!run && (flags == '0) && !q_valid));

endmodule

bind vcop_ctrl vcop_ctrl_chk #(.NUM_ERR(vcop_pkg::NUM_ERR), .OVF_W(OVF_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .rf_we   (rf_we),
  .irq     (irq),
  .ie      (ie_q),
  .flags   (flags),
  .clr_vec (clr_vec),
  .srst    (srst_req),
  .push    (push_req),
  .full    (q_full),
  .ovf_cnt (ovf_q),
  .q_valid (q_valid)
);

// File: tb/vcop_ctrl_tb.sv
module vcop_ctrl_tb;

  localparam logic [7:0] ARCH = 8'h5C;
  localparam logic [7:0] REV  = 8'h2A;
  localparam int         QD   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [5:0]  err_evt = '0;
  logic        eng_wrote = 1'b0;
  logic        run, pb_en, irq;
  logic [31:0] lo_bound, hi_bound, plane_mask, r0_init;
  logic [7:0]  rop;
  logic        rf_we;
  logic [6:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        q_valid, q_kind;
  logic [6:0]  q_idx;
  logic [31:0] q_data;
  logic        q_pop = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  vcop_ctrl #(.QUEUE_DEPTH(QD), .ARCH_CODE(ARCH), .CHIP_REV(REV)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .err_evt(err_evt), .eng_wrote(eng_wrote),
    .run(run), .pb_en(pb_en), .irq(irq), .lo_bound(lo_bound),
    .hi_bound(hi_bound), .plane_mask(plane_mask), .rop(rop),
    .r0_init(r0_init), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .q_valid(q_valid), .q_kind(q_kind), .q_idx(q_idx), .q_data(q_data),
    .q_pop(q_pop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    @(negedge clk); err_evt = v;
    @(negedge clk); err_evt = '0;
  endtask

  task automatic pop_one();
    @(negedge clk); q_pop = 1'b1;
    @(negedge clk); q_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 run", {31'b0, run}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 q_valid", {31'b0, q_valid}, 0);
    chk("R1 rf_we", {31'b0, rf_we}, 0);
    bus_read(13'h000, d);
    chk("R1 control word", d, 32'h0000_8000);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_write(13'h010, 32'hA5A5_5A5A); bus_read(13'h010, d);
    chk("R2 plane mask", d, 32'hA5A5_5A5A);
    chk("R2 plane mask out", plane_mask, 32'hA5A5_5A5A);
    bus_write(13'h014, 32'h0000_01FF); bus_read(13'h014, d);
    chk("R2 rop width", d, 32'h0000_00FF);
    chk("R2 rop out", {24'b0, rop}, 32'hFF);
    bus_write(13'h008, 32'h0000_1000); bus_write(13'h00C, 32'h0000_2000);
    bus_read(13'h008, d); chk("R2 lower bound", d, 32'h1000);
    bus_read(13'h00C, d); chk("R2 upper bound", d, 32'h2000);
    bus_write(13'h01C, 32'h0BAD_F00D); bus_read(13'h01C, d);
    chk("R2 diagnostics", d, 32'h0BAD_F00D);
    bus_write(13'h02C, 32'h7777_0001); bus_read(13'h02C, d);
    chk("R2 r0 init", d, 32'h7777_0001);
    chk("R2 r0 init out", r0_init, 32'h7777_0001);
    bus_read(13'h028, d);
    chk("R2 identity", d, {16'b0, REV, ARCH});
  endtask

  task automatic t_mirror();
    logic [31:0] d;
    bus_write(13'h1008, 32'hDEAD_0000);
    bus_write(13'h100C, 32'hDEAD_0001);
    bus_read(13'h0008, d); chk("R3 lower bound protected", d, 32'h1000);
    bus_read(13'h100C, d); chk("R3 upper bound mirror read", d, 32'h2000);
    chk("R3 lower bound out", lo_bound, 32'h1000);
    bus_write(13'h1010, 32'h0000_1234);
    bus_read(13'h0010, d); chk("R3 mirror mask write", d, 32'h1234);
  endtask

  task automatic t_direct_stopped();
    bus_write(13'h100 + 13'(4 * 9), 32'hCAFE_0009);
    chk("R4 rf_we", {31'b0, rf_we}, 1);
    chk("R4 rf_idx", {25'b0, rf_idx}, 9);
    chk("R4 rf_wdata", rf_wdata, 32'hCAFE_0009);
    @(negedge clk);
    chk("R4 single pulse", {31'b0, rf_we}, 0);
    bus_write(13'h2FC, 32'h0000_007F);
    chk("R4 last index", {24'b0, rf_we, rf_idx}, 32'h0000_00FF);
  endtask

  task automatic t_direct_running();
    logic [31:0] d;
    bus_write(13'h000, 32'h0000_4080);
    chk("R11 run out", {31'b0, run}, 1);
    bus_write(13'h100 + 13'(4 * 3), 32'h1111_1111);
    chk("R5 no strobe", {31'b0, rf_we}, 0);
    bus_read(13'h000, d);
    chk("R5 bad-access flag", d, 32'h0000_C088);
    chk("R7 irq raised", {31'b0, irq}, 1);
    bus_read(13'h004, d);
    chk("R7 error word", d, 32'h0000_0088);
    bus_write(13'h000, 32'h0000_4088);
    @(negedge clk);
    chk("R7 irq dropped", {31'b0, irq}, 0);
    bus_read(13'h000, d);
    chk("R6 cleared via control", d, 32'h0000_C080);
    bus_write(13'h000, 32'h0000_0080);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_evt(6'b010101);
    bus_read(13'h004, d);
    chk("R6 event flags", d, 32'h0000_0095);
    bus_write(13'h004, 32'h0000_0015);
    bus_read(13'h000, d);
    chk("R6 cleared via error reg", d, 32'h0000_8080);
    @(negedge clk);
    err_evt = 6'h01;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 13'h004; bus_wdata = 32'h1;
    @(negedge clk);
    err_evt = '0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_read(13'h004, d);
    chk("R6 set wins over clear", d, 32'h0000_0081);
    bus_write(13'h000, 32'h0000_0001);
    pulse_evt(6'b000010);
    @(negedge clk);
    chk("R7 irq held off by enable", {31'b0, irq}, 0);
    bus_read(13'h004, d);
    chk("R7 error bit7 without enable", d, 32'h0000_0002);
    bus_write(13'h004, 32'h0000_003F);
    bus_write(13'h000, 32'h0000_0080);
  endtask

  task automatic t_queue();
    logic [31:0] d;
    bus_write(13'h300 + 13'(4 * 5), 32'h0000_0011);
    bus_write(13'h020, 32'h0000_0022);
    chk("R8 head valid", {31'b0, q_valid}, 1);
    chk("R8 head queued write", {24'b0, q_kind, q_idx}, 32'h0000_0085);
    chk("R8 head data", q_data, 32'h11);
    bus_read(13'h000, d);
    chk("R8 not empty", d, 32'h0000_0080);
    pop_one();
    chk("R8 second entry", {24'b0, q_kind, q_idx}, 32'h0);
    chk("R8 second data", q_data, 32'h22);
    pop_one();
    chk("R8 drained", {31'b0, q_valid}, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < QD + 1; i++)
      bus_write(13'h300 + 13'(4 * i), 32'h100 + 32'(i));
    bus_read(13'h018, d);
    chk("R9 overflow count", d, 32'h1);
    bus_read(13'h000, d);
    chk("R9 overflow flag", d, 32'h0000_00A0);
    for (int i = 0; i < QD; i++) begin
      chk("R9 kept order idx", {25'b0, q_idx}, 32'(i));
      chk("R9 kept order data", q_data, 32'h100 + 32'(i));
      pop_one();
    end
    chk("R9 dropped entry absent", {31'b0, q_valid}, 0);
    bus_write(13'h018, 32'h0);
    bus_read(13'h018, d);
    chk("R9 counter cleared", d, 32'h0);
    bus_write(13'h000, 32'h0000_00A0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    bus_write(13'h000, 32'h0000_5080);
    chk("R11 pb_en out", {31'b0, pb_en}, 1);
    bus_write(13'h300, 32'h5);
    pulse_evt(6'b000010);
    eng_wrote = 1'b1; @(negedge clk); eng_wrote = 1'b0;
    bus_write(13'h030, 32'h0);
    @(negedge clk);
    chk("R10 queue emptied", {31'b0, q_valid}, 0);
    chk("R10 run cleared", {31'b0, run}, 0);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    bus_read(13'h000, d);
    chk("R10 control after soft reset", d, 32'h0000_9080);
    bus_read(13'h010, d);
    chk("R10 mask kept", d, 32'h1234);
  endtask

  task automatic t_wrote();
    logic [31:0] d;
    @(negedge clk); eng_wrote = 1'b1;
    @(negedge clk); eng_wrote = 1'b0;
    bus_read(13'h000, d);
    chk("R11 write indication set", d, 32'h0000_B080);
    bus_write(13'h000, 32'h0000_3080);
    bus_read(13'h000, d);
    chk("R11 write indication cleared", d, 32'h0000_9080);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_mirror();
    t_direct_stopped();
    t_direct_running();
    t_events();
    t_queue();
    t_overflow();
    t_soft_reset();
    t_wrote();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule